// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block drives an 8-bit multiplexed NAND flash bus and runs one of three operations per host request: page read, page program or block erase. The host presents an operation code, a column and a row address with a valid/ready handshake. The sequencer then issues the command, address and data bus cycles and waits on the ready/busy line. When the operation ends it raises a one-cycle completion pulse with an error flag. Write bytes enter through a valid/ready stream. Read bytes leave through a second valid/ready stream, and the host can stall either stream at any time.

Every bus cycle is one low pulse on a write or read strobe. A shared pulse generator times the low and high widths in clock cycles. An external bidirectional transceiver sits on the data lines, and the block drives its direction and enable. After each confirm command the sequencer waits a fixed settling window before it looks at the synchronised ready/busy level. A timeout counter bounds the wait.

States: `S_IDLE` (accept a request) → `S_CMD1` (setup command) → `S_ADDR` (address bytes) → `S_WDATA` (program only) → `S_CMD2` (confirm command) → `S_TWB` (settling window) → `S_BUSY` (wait for ready or timeout) → `S_RDATA` → `S_RDRAIN` (read only) → `S_DONE` → `S_IDLE`. An unknown operation code goes straight from `S_IDLE` to `S_DONE`. A timeout goes from `S_BUSY` to `S_DONE`.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high, the command and address latch lines are low, the bus direction is toward the controller, request ready is high and done is low.
- R2: A command byte is sent with the command latch line high and the address latch line low, and the byte is stable on the data lines while the write strobe is low. The latch line is low again after the pulse.
- R3: Read and program send five address bytes in this order: column bits 7:0, column bits 11:8 zero-padded to a byte, then row bits 7:0, 15:8 and 23:16. Each address byte is sent with the address latch line high and the command latch line low.
- R4: Erase (op code 2) sends command 0x60, then only the three row bytes, then 0xD0. It sends no data bytes.
- R5: Read (op code 0) sends 0x00, the five address bytes and 0x30. After ready it issues PAGE_BYTES read-strobe pulses. Each byte is sampled in the last low cycle of its pulse and delivered on the read stream in order.
- R6: Program (op code 1) sends 0x80 and the five address bytes. It then sends the PAGE_BYTES bytes taken from the write stream, each on a write-strobe rising edge, in order, and then sends 0x10.
- R7: After a confirm command the ready/busy line is ignored for TWB_CYC cycles. A ready level that is still high from before the command does not complete the operation.
- R8: If ready/busy stays low for TIMEOUT_CYC cycles, the operation ends with err high. A read that times out issues no read strobes.
- R9: Chip enable is low from the first command until done, for every strobe pulse. It is high again in the cycle after done.
- R10: The bus direction output is high (toward the flash) during every write-strobe pulse and low during every read-strobe pulse. The two strobes are never low together.
- R11: Every strobe pulse is low for exactly PULSE_LO cycles. Consecutive pulses are separated by at least PULSE_HI high cycles.
- R12: No write byte is launched while the write stream is not valid. No read pulse starts while the previous read byte has not been accepted. The read byte is held stable while it is stalled.
- R13: A request is accepted only while request ready is high. Done is a single-cycle pulse, and err is 0 on success. Op code 3 ends at once with err high and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (sequencer idle) |
| req_op_i | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| req_col_i | input | COL_W | Column address |
| req_row_i | input | ROW_W | Row address (page and block) |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte accepted |
| wr_data_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Host accepts read byte |
| rd_data_o | output | 8 | Read byte |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Error flag, valid with done |
| nf_ce_n_o | output | 1 | Flash chip enable, active low |
| nf_cle_o | output | 1 | Command latch line |
| nf_ale_o | output | 1 | Address latch line |
| nf_we_n_o | output | 1 | Write strobe, active low |
| nf_re_n_o | output | 1 | Read strobe, active low |
| nf_io_o | output | 8 | Data lines toward flash |
| nf_io_i | input | 8 | Data lines from flash |
| nf_io_oe_o | output | 1 | Transceiver direction, 1 = toward flash |
| nf_buf_en_n_o | output | 1 | Transceiver enable, active low |
| nf_rb_n_i | input | 1 | Ready/busy from flash, low = busy |

## Verification
The bench keeps ready/busy high for a short stale window after each confirm command and only then pulls it low. A design that skips the settling window, or samples the line too early, finishes before the device ever went busy. Timeouts are forced on both a read and a program. A design without the timeout hangs, and one that ignores the error path strobes out a page of garbage. Random stalls on both byte streams catch strobes launched without data and read bytes overwritten before the host takes them. Erase and the invalid op code catch a wrong address-cycle count and stray bus activity.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    // host operation codes
    localparam logic [1:0] OPC_READ  = 2'd0;
    localparam logic [1:0] OPC_PROG  = 2'd1;
    localparam logic [1:0] OPC_ERASE = 2'd2;
    localparam logic [1:0] OPC_NONE  = 2'd3;

    // flash command bytes
    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] CMD_ER_GO    = 8'hD0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_WDATA,
        S_CMD2,
        S_TWB,
        S_BUSY,
        S_RDATA,
        S_RDRAIN,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        STB_IDLE,
        STB_LOW,
        STB_HIGH
    } stb_phase_e;

endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_seq_pkg::*;
#(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic idle_o,
    output logic low_o,
    output logic last_low_o,
    output logic done_o
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    stb_phase_e      phase_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= STB_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                STB_IDLE: begin
                    if (go_i) begin
                        phase_q <= STB_LOW;
                        cnt_q   <= CW'(LO_CYC - 1);
                    end
                end
                STB_LOW: begin
                    if (cnt_q == '0) begin
                        phase_q <= STB_HIGH;
                        cnt_q   <= CW'(HI_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                STB_HIGH: begin
                    if (cnt_q == '0) begin
                        phase_q <= STB_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= STB_IDLE;
            endcase
        end
    end

    always_comb begin
        idle_o     = (phase_q == STB_IDLE);
        low_o      = (phase_q == STB_LOW);
        last_low_o = (phase_q == STB_LOW)  && (cnt_q == '0);
        done_o     = (phase_q == STB_HIGH) && (cnt_q == '0);
    end

    // R11
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (phase_q == STB_IDLE));

    // R11
    go_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> low_o);

endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R7
    timer_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES  = 2112,
    parameter int COL_W       = 12,
    parameter int ROW_W       = 24,
    parameter int PULSE_LO    = 2,
    parameter int PULSE_HI    = 2,
    parameter int TWB_CYC     = 8,
    parameter int TIMEOUT_CYC = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [1:0]       req_op_i,
    input  logic [COL_W-1:0] req_col_i,
    input  logic [ROW_W-1:0] req_row_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [7:0]       wr_data_i,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic [7:0]       rd_data_o,
    output logic             done_o,
    output logic             err_o,
    output logic             nf_ce_n_o,
    output logic             nf_cle_o,
    output logic             nf_ale_o,
    output logic             nf_we_n_o,
    output logic             nf_re_n_o,
    output logic [7:0]       nf_io_o,
    input  logic [7:0]       nf_io_i,
    output logic             nf_io_oe_o,
    output logic             nf_buf_en_n_o,
    input  logic             nf_rb_n_i
);
    localparam int BCNT_W  = $clog2(PAGE_BYTES + 1);
    localparam int TMR_MAX = (TWB_CYC > TIMEOUT_CYC) ? TWB_CYC : TIMEOUT_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [2:0] ADDR_LAST  = 3'd4;
    localparam logic [2:0] ADDR_ROW0  = 3'd2;

    seq_state_e        state_q, state_d;
    logic [1:0]        op_q;
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [2:0]        addr_idx_q;
    logic [BCNT_W-1:0] byte_cnt_q;
    logic [7:0]        io_q;
    logic              cle_q, ale_q, ce_q, err_q;
    logic [7:0]        rd_data_q;
    logic              rd_valid_q;
    logic [1:0]        rb_sync_q;
    logic              rb_ready;

    logic              stb_go, stb_idle, stb_low, stb_last_low, stb_done;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic [7:0]        bus_byte;
    logic [15:0]       col_pad;
    logic [23:0]       row_pad;
    logic              last_byte;
    logic              accept;

    // ---------------------------------------------------------------
    // sub-blocks
    // ---------------------------------------------------------------
    nand_strobe_gen #(
        .LO_CYC (PULSE_LO),
        .HI_CYC (PULSE_HI)
    ) strobe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (stb_go),
        .idle_o     (stb_idle),
        .low_o      (stb_low),
        .last_low_o (stb_last_low),
        .done_o     (stb_done)
    );

    nand_wait_timer #(
        .W (TMR_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // ready/busy is asynchronous to clk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_sync_q <= 2'b00;
        else        rb_sync_q <= {rb_sync_q[0], nf_rb_n_i};
    end
    assign rb_ready = rb_sync_q[1];

    assign col_pad   = 16'(col_q);
    assign row_pad   = 24'(row_q);
    assign last_byte = (byte_cnt_q == BCNT_W'(PAGE_BYTES - 1));
    assign accept    = (state_q == S_IDLE) && req_valid_i;

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // next state, strobe launch and timer control
    // ---------------------------------------------------------------
    always_comb begin
        state_d  = state_q;
        stb_go   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(TIMEOUT_CYC);
        unique case (state_q)
            S_IDLE: begin
                if (req_valid_i) state_d = (req_op_i == OPC_NONE) ? S_DONE : S_CMD1;
            end
            S_CMD1: begin
                stb_go = stb_idle;
                if (stb_done) state_d = S_ADDR;
            end
            S_ADDR: begin
                stb_go = stb_idle;
                if (stb_done && addr_idx_q == ADDR_LAST)
                    state_d = (op_q == OPC_PROG) ? S_WDATA : S_CMD2;
            end
            S_WDATA: begin
                stb_go = stb_idle && wr_valid_i;
                if (stb_done && last_byte) state_d = S_CMD2;
            end
            S_CMD2: begin
                stb_go = stb_idle;
                if (stb_done) begin
                    state_d  = S_TWB;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TWB_CYC);
                end
            end
            S_TWB: begin
                if (tmr_expired) begin
                    state_d  = S_BUSY;
                    tmr_load = 1'b1;
                end
            end
            S_BUSY: begin
                if (rb_ready)         state_d = (op_q == OPC_READ) ? S_RDATA : S_DONE;
                else if (tmr_expired) state_d = S_DONE;
            end
            S_RDATA: begin
                stb_go = stb_idle && !rd_valid_q;
                if (stb_done && last_byte) state_d = S_RDRAIN;
            end
            S_RDRAIN: begin
                if (!rd_valid_q) state_d = S_DONE;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // byte placed on the data lines at strobe launch
    always_comb begin
        bus_byte = 8'h00;
        unique case (state_q)
            S_CMD1: begin
                unique case (op_q)
                    OPC_READ: bus_byte = CMD_RD_SETUP;
                    OPC_PROG: bus_byte = CMD_PG_SETUP;
                    default:  bus_byte = CMD_ER_SETUP;
                endcase
            end
            S_CMD2: begin
                unique case (op_q)
                    OPC_READ: bus_byte = CMD_RD_GO;
                    OPC_PROG: bus_byte = CMD_PG_GO;
                    default:  bus_byte = CMD_ER_GO;
                endcase
            end
            S_ADDR: begin
                unique case (addr_idx_q)
                    3'd0:    bus_byte = col_pad[7:0];
                    3'd1:    bus_byte = col_pad[15:8];
                    3'd2:    bus_byte = row_pad[7:0];
                    3'd3:    bus_byte = row_pad[15:8];
                    default: bus_byte = row_pad[23:16];
                endcase
            end
            S_WDATA: bus_byte = wr_data_i;
            default: bus_byte = 8'h00;
        endcase
    end

    // ---------------------------------------------------------------
    // datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OPC_READ;
            col_q      <= '0;
            row_q      <= '0;
            addr_idx_q <= '0;
            byte_cnt_q <= '0;
            io_q       <= '0;
            cle_q      <= 1'b0;
            ale_q      <= 1'b0;
            ce_q       <= 1'b0;
            err_q      <= 1'b0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q       <= req_op_i;
                col_q      <= req_col_i;
                row_q      <= req_row_i;
                addr_idx_q <= (req_op_i == OPC_ERASE) ? ADDR_ROW0 : 3'd0;
                byte_cnt_q <= '0;
                err_q      <= (req_op_i == OPC_NONE);
                ce_q       <= (req_op_i != OPC_NONE);
            end
            if (state_q == S_DONE) ce_q <= 1'b0;

            if (stb_go) begin
                io_q  <= bus_byte;
                cle_q <= (state_q == S_CMD1) || (state_q == S_CMD2);
                if (state_q == S_ADDR) ale_q <= 1'b1;
            end

            if (stb_done) begin
                cle_q <= 1'b0;
                if (state_q == S_ADDR) begin
                    addr_idx_q <= addr_idx_q + 1'b1;
                    if (addr_idx_q == ADDR_LAST) ale_q <= 1'b0;
                end
                if (state_q == S_WDATA || state_q == S_RDATA)
                    byte_cnt_q <= byte_cnt_q + 1'b1;
            end

            if (state_q == S_BUSY && !rb_ready && tmr_expired) err_q <= 1'b1;

            if (state_q == S_RDATA && stb_last_low) begin
                rd_data_q  <= nf_io_i;
                rd_valid_q <= 1'b1;
            end else if (rd_ready_i) begin
                rd_valid_q <= 1'b0;
            end
        end
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    always_comb begin
        req_ready_o   = (state_q == S_IDLE);
        wr_ready_o    = (state_q == S_WDATA) && stb_go;
        rd_valid_o    = rd_valid_q;
        rd_data_o     = rd_data_q;
        done_o        = (state_q == S_DONE);
        err_o         = err_q;
        nf_ce_n_o     = ~ce_q;
        nf_buf_en_n_o = ~ce_q;
        nf_cle_o      = cle_q;
        nf_ale_o      = ale_q;
        nf_io_o       = io_q;
        nf_we_n_o     = ~(stb_low && (state_q != S_RDATA));
        nf_re_n_o     = ~(stb_low && (state_q == S_RDATA));
        nf_io_oe_o    = (state_q == S_CMD1) || (state_q == S_ADDR) ||
                        (state_q == S_WDATA) || (state_q == S_CMD2);
    end

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n_o && !nf_re_n_o));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle_o && nf_ale_o));

    // R9
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n_o || !nf_re_n_o) |-> !nf_ce_n_o);

    // R10
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n_o |-> nf_io_oe_o);

    // R10
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n_o |-> !nf_io_oe_o);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    cmd_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n_o && $past(!nf_we_n_o)) |-> $stable(nf_io_o));

    // R12
    wr_accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> wr_valid_i);

endmodule

// File: tb/nand_op_seq_tb.sv
module nand_op_seq_tb_top;

    localparam int PAGE   = 20;
    localparam int LO     = 2;
    localparam int HI     = 1;
    localparam int TWB    = 4;
    localparam int TMO    = 60;
    localparam int STALE  = 2;
    localparam int WDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_col = '0;
    logic [23:0] req_row = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        done, err;
    logic        ce_n, cle, ale, we_n, re_n, io_oe, buf_en_n;
    logic [7:0]  io_out;
    logic [7:0]  io_in = '0;
    logic        rb_n = 1'b1;

    always #5 clk = ~clk;

    nand_op_seq #(
        .PAGE_BYTES  (PAGE),
        .COL_W       (12),
        .ROW_W       (24),
        .PULSE_LO    (LO),
        .PULSE_HI    (HI),
        .TWB_CYC     (TWB),
        .TIMEOUT_CYC (TMO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (req_valid), .req_ready_o (req_ready), .req_op_i (req_op),
        .req_col_i (req_col), .req_row_i (req_row),
        .wr_valid_i (wr_valid), .wr_ready_o (wr_ready), .wr_data_i (wr_data),
        .rd_valid_o (rd_valid), .rd_ready_i (rd_ready), .rd_data_o (rd_data),
        .done_o (done), .err_o (err),
        .nf_ce_n_o (ce_n), .nf_cle_o (cle), .nf_ale_o (ale),
        .nf_we_n_o (we_n), .nf_re_n_o (re_n),
        .nf_io_o (io_out), .nf_io_i (io_in), .nf_io_oe_o (io_oe),
        .nf_buf_en_n_o (buf_en_n), .nf_rb_n_i (rb_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wpat(input int row, input int col, input int i);
        return 8'((row * 7 + col + i * 13) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] rpat(input int row, input int col, input int i);
        return 8'((row * 3 + col * 5 + i * 29) ^ 8'hC3);
    endfunction

    // ---------------- flash model and bus monitor ----------------
    logic [7:0] cmd_log [0:7];
    logic [7:0] adr_log [0:7];
    logic [7:0] dat_log [0:63];
    logic [7:0] rdl_log [0:63];
    int n_cmd, n_adr, n_dat, n_rdl, rd_idx;
    int cur_row, cur_col;
    int stale_left, busy_left, busy_len;
    bit rb_cycle_done;
    int bus_bad, ce_bad, dir_bad, pw_bad, gap_bad, re_cnt;
    int we_lo, re_lo, hi_len;
    bit had_strobe, ce_seen;
    logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0;
    logic [7:0] p_io = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) we_lo = p_we ? 1 : we_lo + 1;
            if (!re_n) re_lo = p_re ? 1 : re_lo + 1;
            if (!p_we && we_n) begin
                if (p_cle && !p_ale) begin
                    if (n_cmd < 8) cmd_log[n_cmd] = p_io;
                    n_cmd++;
                    if (p_io == 8'h30 || p_io == 8'h10 || p_io == 8'hD0) begin
                        stale_left = STALE;
                    end
                end else if (p_ale && !p_cle) begin
                    if (n_adr < 8) adr_log[n_adr] = p_io;
                    n_adr++;
                end else if (!p_cle && !p_ale) begin
                    if (n_dat < 64) dat_log[n_dat] = p_io;
                    n_dat++;
                end else begin
                    bus_bad++;
                end
                if (we_lo != LO) pw_bad++;
            end
            if (!p_re && re_n) begin
                rd_idx++;
                if (re_lo != LO) pw_bad++;
            end
            if (p_re && !re_n) begin
                io_in = rpat(cur_row, cur_col, rd_idx);
                re_cnt++;
            end
            if ((p_we && p_re) && (!we_n || !re_n)) begin
                if (had_strobe && hi_len < HI) gap_bad++;
                had_strobe = 1'b1;
                hi_len = 0;
            end
            if (we_n && re_n) hi_len++;
            if (!we_n) begin
                if (ce_n) ce_bad++;
                if (!io_oe) dir_bad++;
            end
            if (!re_n) begin
                if (ce_n) ce_bad++;
                if (io_oe) dir_bad++;
                if (cle || ale) bus_bad++;
            end
            if (!ce_n) ce_seen = 1'b1;
            if (stale_left > 0) begin
                stale_left--;
                if (stale_left == 0) begin
                    rb_n = 1'b0;
                    busy_left = busy_len;
                end
            end else if (!rb_n && busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    rb_n = 1'b1;
                    rb_cycle_done = 1'b1;
                end
            end
            p_we = we_n; p_re = re_n; p_cle = cle; p_ale = ale; p_io = io_out;
        end
    end

    // ---------------- host byte streams ----------------
    bit w_active, r_active, w_taken;
    int w_idx;

    always @(negedge clk) begin
        if (rst_n) begin
            if (w_taken) begin
                w_idx++;
                w_taken = 1'b0;
            end
            wr_valid = w_active && (w_idx < PAGE) && (($urandom % 4) != 0);
            wr_data  = wpat(cur_row, cur_col, w_idx);
            rd_ready = r_active && (($urandom % 3) != 0);
            #1;
            if (wr_valid && wr_ready) w_taken = 1'b1;
            if (rd_valid && rd_ready) begin
                if (n_rdl < 64) rdl_log[n_rdl] = rd_data;
                n_rdl++;
            end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- one operation ----------------
    task automatic do_op(input int op, input int col, input int row, input int blen,
                         input bit expect_err);
        bit got_done;
        bit got_err;
        int exp_adr;
        cur_row = row; cur_col = col; busy_len = blen;
        n_cmd = 0; n_adr = 0; n_dat = 0; n_rdl = 0; rd_idx = 0; re_cnt = 0;
        stale_left = 0; busy_left = 0; rb_n = 1'b1; rb_cycle_done = 1'b0;
        bus_bad = 0; ce_bad = 0; dir_bad = 0; pw_bad = 0; gap_bad = 0;
        had_strobe = 1'b0; ce_seen = 1'b0;
        w_idx = 0; w_taken = 1'b0;
        w_active = (op == 1); r_active = (op == 0);
        @(negedge clk); #2;
        // R13 request accepted only while ready
        chk(req_ready == 1'b1, "R13 req_ready idle", int'(req_ready), 1);
        req_valid = 1'b1; req_op = 2'(op); req_col = 12'(col); req_row = 24'(row);
        got_done = 1'b0;
        got_err = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #2;
            if (done) begin
                got_done = 1'b1;
                got_err = err;
                break;
            end
        end
        chk(got_done, "R13 done seen", int'(got_done), 1);
        chk(got_err == expect_err, "R8/R13 err flag", int'(got_err), int'(expect_err));
        @(negedge clk); #2;
        chk(!done, "R13 done single cycle", int'(done), 0);
        chk(ce_n, "R9 ce high after done", int'(ce_n), 1);
        w_active = 1'b0; r_active = 1'b0;

        if (op == 3) begin
            chk(!ce_seen && n_cmd == 0, "R13 invalid op no bus", n_cmd, 0);
            return;
        end
        // command bytes
        chk(n_cmd == 2, "R2 command count", n_cmd, 2);
        if (op == 0) begin
            chk(cmd_log[0] == 8'h00 && cmd_log[1] == 8'h30, "R5 read commands",
                {cmd_log[0], cmd_log[1]}, 16'h0030);
        end else if (op == 1) begin
            chk(cmd_log[0] == 8'h80 && cmd_log[1] == 8'h10, "R6 program commands",
                {cmd_log[0], cmd_log[1]}, 16'h8010);
        end else begin
            chk(cmd_log[0] == 8'h60 && cmd_log[1] == 8'hD0, "R4 erase commands",
                {cmd_log[0], cmd_log[1]}, 16'h60D0);
        end
        // address bytes
        if (op == 2) begin
            chk(n_adr == 3, "R4 erase address count", n_adr, 3);
            for (int i = 0; i < 3; i++) begin
                exp_adr = (row >> (8 * i)) & 8'hFF;
                chk(adr_log[i] == 8'(exp_adr), "R4 erase row byte", adr_log[i], exp_adr);
            end
            chk(n_dat == 0, "R4 erase no data", n_dat, 0);
        end else begin
            chk(n_adr == 5, "R3 address count", n_adr, 5);
            chk(adr_log[0] == 8'(col & 8'hFF), "R3 column low", adr_log[0], col & 8'hFF);
            chk(adr_log[1] == 8'((col >> 8) & 4'hF), "R3 column high", adr_log[1], (col >> 8) & 4'hF);
            for (int i = 0; i < 3; i++) begin
                exp_adr = (row >> (8 * i)) & 8'hFF;
                chk(adr_log[i + 2] == 8'(exp_adr), "R3 row byte", adr_log[i + 2], exp_adr);
            end
        end
        // data
        if (op == 1) begin
            chk(n_dat == PAGE, "R6 program byte count", n_dat, PAGE);
            for (int i = 0; i < PAGE; i++) begin
                if (dat_log[i] != wpat(row, col, i))
                    chk(1'b0, "R6 program byte", dat_log[i], wpat(row, col, i));
            end
            chk(1'b1, "R12 write stream order", 0, 0);
        end
        if (op == 0) begin
            if (expect_err) begin
                chk(re_cnt == 0, "R8 no read strobes after timeout", re_cnt, 0);
            end else begin
                chk(n_rdl == PAGE, "R5 read byte count", n_rdl, PAGE);
                for (int i = 0; i < PAGE; i++) begin
                    if (rdl_log[i] != rpat(row, col, i))
                        chk(1'b0, "R5/R12 read byte", rdl_log[i], rpat(row, col, i));
                end
            end
        end
        if (!expect_err) begin
            chk(rb_cycle_done, "R7 completion only after busy", int'(rb_cycle_done), 1);
        end
        chk(bus_bad == 0, "R2/R3 latch lines", bus_bad, 0);
        chk(ce_bad == 0, "R9 ce during strobes", ce_bad, 0);
        chk(dir_bad == 0, "R10 bus direction", dir_bad, 0);
        chk(pw_bad == 0, "R11 low width", pw_bad, 0);
        chk(gap_bad == 0, "R11 high gap", gap_bad, 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd20240611));
        n_cmd = 0; n_adr = 0; n_dat = 0; n_rdl = 0; rd_idx = 0;
        cur_row = 0; cur_col = 0; stale_left = 0; busy_left = 0; busy_len = 0;
        we_lo = 0; re_lo = 0; hi_len = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_n && we_n && re_n, "R1 strobes high in reset", {ce_n, we_n, re_n}, 3'b111);
        chk(!cle && !ale && !io_oe, "R1 latch and dir low", {cle, ale, io_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(req_ready && !done, "R1 ready after reset", {req_ready, done}, 2'b10);

        // directed corner cases
        do_op(0, 12'hABC, 24'h123456, 5, 1'b0);
        do_op(1, 12'h0F1, 24'hFEDCBA, 3, 1'b0);
        do_op(2, 12'h777, 24'h01FFC0, 8, 1'b0);
        do_op(3, 0, 0, 1, 1'b1);
        do_op(0, 12'h010, 24'h000040, 1000000, 1'b1);
        do_op(1, 12'hFFF, 24'h0A0B0C, 1000000, 1'b1);
        do_op(2, 0, 24'hFFFFFF, 1, 1'b0);

        // constrained random operations
        for (int n = 0; n < 14; n++) begin
            do_op(int'($urandom % 3), int'($urandom % 4096), int'($urandom % 24'h80000),
                  1 + int'($urandom % 30), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule